// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

The block sends one parallel data word per frame as a synchronous serial stream. The word goes out least significant bit first on a serial data line. A gated data clock toggles only while data bits are on the line. Two framing strobes go with the stream: a request-to-send level that spans the data bits, and a data strobe that marks the first bit. Everything runs from one system clock. An internal half-bit enable, set by a divider input, paces each bit cell. Each cell has two equal halves. The data clock sits at the inactive level in the first half and at the active level in the second half, so the active edge always falls mid-cell. Data changes only at the start of a cell, on the inactive edge.

A mode input selects synchronous operation or serial-expansion operation. In synchronous mode the clock standby level, the clock active edge and the request-to-send active level are all set by inputs. A two-bit clock-source select can switch the data clock off. In serial-expansion mode the clock idles high and its active edge is rising. Both strobes then stay inactive. The configuration inputs are meant to change only while the block is idle.

Top module: `sync_frame_tx`

## Requirements
- R1: After reset, busy_o is 0, sout_o is 1, sds_o is 0 and rts_o is at its inactive level (the inverse of rts_act_i).
- R2: In a frame, sout_o carries data bit 0 first and bit 7 last. Each bit is held for one whole cell. sout_o is 1 whenever busy_o is 0.
- R3: In a frame with the clock enabled, each cell's first half has sclk_o at the inverse of the active level and the second half has it at the active level. Outside frames sclk_o is at its standby level. sout_o changes only while sclk_o is at the inactive level.
- R4: With sync_mode_i = 0 and clk_sel_i = 2'b11 (serial expansion), sclk_o has standby level 1 and rising active edges.
- R5: With sync_mode_i = 1, the standby level of sclk_o equals clk_idle_i. Active edges are rising when clk_rise_i = 1 and falling when clk_rise_i = 0.
- R6: With sync_mode_i = 1 and clk_sel_i = 2'b00, sclk_o stays at clk_idle_i through the whole frame.
- R7: With sync_mode_i = 1, rts_o equals rts_act_i from the first cycle of the bit-0 cell through the last cycle of the bit-7 cell. At all other times it equals the inverse.
- R8: sds_o is 1 only during the bit-0 cell of a frame in synchronous mode. It is 0 everywhere else.
- R9: With sync_mode_i = 0, sds_o is 0 and rts_o is inactive. If clk_sel_i is not 2'b11, sclk_o stays at 1.
- R10: A start_i sampled while idle loads data_i. busy_o is then 1 for exactly 16*(bit_div_i+1) cycles from the next cycle. A start_i sampled while busy_o is 1 is ignored. A start_i held high across the end of a frame starts the next frame after exactly one idle cycle.
- R11: Each half cell lasts bit_div_i+1 cycles, so consecutive active clock edges in a frame are 2*(bit_div_i+1) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 = synchronous mode, 0 = serial-expansion or clock-off |
| clk_sel_i | input | 2 | Clock-source select (2'b00 off in sync mode, 2'b11 expansion otherwise) |
| clk_idle_i | input | 1 | Data clock standby level in synchronous mode |
| clk_rise_i | input | 1 | Active edge in synchronous mode: 1 rising, 0 falling |
| rts_act_i | input | 1 | Active level of rts_o |
| bit_div_i | input | DIV_W | Half-cell length minus one, in system cycles |
| start_i | input | 1 | Load data_i and begin a frame when idle |
| data_i | input | DATA_W | Word to send |
| busy_o | output | 1 | Frame in progress |
| sout_o | output | 1 | Serial data, least significant bit first |
| sclk_o | output | 1 | Gated data clock |
| rts_o | output | 1 | Request-to-send strobe |
| sds_o | output | 1 | First-bit data strobe |

## Verification
Two events can fall in the same cycle: a new start request and the end of the current frame, when busy and request-to-send drop together. The bench holds start_i high from the middle of one frame past its end and changes data_i after the first load. It then checks three things: the first word goes out intact, there is exactly one idle cycle between the two frames, and the second frame carries the new word. A separate single start pulse in the middle of a frame checks that the word in flight is not disturbed and that the frame length does not change.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam logic [1:0] SEL_OFF = 2'b00;
  localparam logic [1:0] SEL_EXP = 2'b11;

  typedef struct packed {
    logic       sync;
    logic [1:0] sel;
    logic       idle;
    logic       rise;
    logic       rts_act;
  } sft_cfg_t;
endpackage

// File: rtl/sft_rate_gen.sv
module sft_rate_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              bit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              half_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              half_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      shreg_q <= '1;
      idx_q   <= '0;
      half_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        shreg_q <= data_i;
        idx_q   <= '0;
        half_q  <= 1'b0;
      end
    end else if (tick_i) begin
      if (!half_q) begin
        half_q <= 1'b1;
      end else begin
        // cell boundary: next bit, or frame end after the last cell
        half_q  <= 1'b0;
        shreg_q <= {1'b1, shreg_q[DATA_W-1:1]};
        if (idx_q == LAST) busy_q <= 1'b0;
        else               idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign bit_o  = shreg_q[0];
  assign idx_o  = idx_q;
  assign half_o = half_q;
endmodule

// File: rtl/sft_pins.sv
module sft_pins
  import sft_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  sft_cfg_t         cfg_i,
  input  logic             busy_i,
  input  logic             bit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             half_i,
  output logic             sout_o,
  output logic             sclk_o,
  output logic             rts_o,
  output logic             sds_o
);
  logic clk_en, standby, act_lvl;

  always_comb begin
    if (cfg_i.sync) begin
      clk_en  = (cfg_i.sel != SEL_OFF);
      standby = cfg_i.idle;
      act_lvl = cfg_i.rise;
    end else begin
      clk_en  = (cfg_i.sel == SEL_EXP);
      standby = 1'b1;
      act_lvl = 1'b1;
    end
  end

  // first half inactive level, second half active level: active edge mid-cell
  assign sclk_o = (busy_i && clk_en) ? (half_i ? act_lvl : ~act_lvl) : standby;
  assign sout_o = busy_i ? bit_i : 1'b1;
  assign rts_o  = (cfg_i.sync && busy_i) ? cfg_i.rts_act : ~cfg_i.rts_act;
  assign sds_o  = cfg_i.sync && busy_i && (idx_i == '0);
endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx
  import sft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              clk_idle_i,
  input  logic              clk_rise_i,
  input  logic              rts_act_i,
  input  logic [DIV_W-1:0]  bit_div_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              sout_o,
  output logic              sclk_o,
  output logic              rts_o,
  output logic              sds_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  sft_cfg_t         cfg;
  logic             tick, busy, bit_val, half;
  logic [IDX_W-1:0] idx;

  assign cfg = '{sync: sync_mode_i, sel: clk_sel_i, idle: clk_idle_i,
                 rise: clk_rise_i, rts_act: rts_act_i};

  sft_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (bit_div_i),
    .tick_o (tick)
  );

  sft_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .data_i  (data_i),
    .tick_i  (tick),
    .busy_o  (busy),
    .bit_o   (bit_val),
    .idx_o   (idx),
    .half_o  (half)
  );

  sft_pins #(.IDX_W(IDX_W)) u_pins (
    .cfg_i  (cfg),
    .busy_i (busy),
    .bit_i  (bit_val),
    .idx_i  (idx),
    .half_i (half),
    .sout_o (sout_o),
    .sclk_o (sclk_o),
    .rts_o  (rts_o),
    .sds_o  (sds_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/sync_frame_tx_chk.sv
module sync_frame_tx_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_mode_i,
  input logic [1:0]        clk_sel_i,
  input logic              clk_idle_i,
  input logic              clk_rise_i,
  input logic              rts_act_i,
  input logic [DIV_W-1:0]  bit_div_i,
  input logic              start_i,
  input logic [DATA_W-1:0] data_i,
  input logic              busy_o,
  input logic              sout_o,
  input logic              sclk_o,
  input logic              rts_o,
  input logic              sds_o
);
  AST_IDLE_LINE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sout_o); // R2

  AST_DATA_ON_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$stable(sout_o) && sync_mode_i && clk_sel_i != 2'b00)
      |-> (sclk_o != clk_rise_i)); // R3

  AST_EXP_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && !busy_o) |-> sclk_o); // R4

  AST_CLK_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && clk_sel_i == 2'b00) |-> (sclk_o == clk_idle_i)); // R6

  AST_RTS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rts_o != rts_act_i)); // R7

  AST_SDS_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sds_o |-> (sync_mode_i && busy_o)); // R8

  AST_NO_STROBE_ASYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_i |-> (!sds_o && rts_o != rts_act_i)); // R9
endmodule

bind sync_frame_tx sync_frame_tx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sync_frame_tx_tb.sv
module sync_frame_tx_tb;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sync_mode = 1'b1;
  logic [1:0]        clk_sel = 2'b01;
  logic              clk_idle = 1'b0;
  logic              clk_rise = 1'b1;
  logic              rts_act = 1'b1;
  logic [DIV_W-1:0]  bit_div = 8'd1;
  logic              start = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic              busy_o, sout_o, sclk_o, rts_o, sds_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];

  always #2.5 clk = ~clk;

  sync_frame_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .clk_sel_i(clk_sel),
    .clk_idle_i(clk_idle), .clk_rise_i(clk_rise), .rts_act_i(rts_act),
    .bit_div_i(bit_div), .start_i(start), .data_i(data), .busy_o(busy_o),
    .sout_o(sout_o), .sclk_o(sclk_o), .rts_o(rts_o), .sds_o(sds_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic bit clk_en_exp();
    return sync_mode ? (clk_sel != 2'b00) : (clk_sel == 2'b11);
  endfunction
  function automatic bit standby_exp();
    return sync_mode ? clk_idle : 1'b1;
  endfunction
  function automatic bit act_exp();
    return sync_mode ? clk_rise : 1'b1;
  endfunction

  // monitor: on every active clock edge pop the expected bit cell
  int   cyc = 0;
  int   last_edge = -1;
  logic prev_sclk = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (busy_o) begin
        if (sclk_o != prev_sclk && sclk_o == act_exp()) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6/R9 unexpected clock edge", 1, 0);
          end else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            chk(sout_o == e[2], "R2 data bit at active edge", int'(sout_o), int'(e[2]));
            chk(rts_o == e[1], "R7 rts at active edge", int'(rts_o), int'(e[1]));
            chk(sds_o == e[0], "R8 sds at active edge", int'(sds_o), int'(e[0]));
          end
          if (last_edge >= 0)
            chk(cyc - last_edge == 2 * (int'(bit_div) + 1), "R11 edge spacing",
                cyc - last_edge, 2 * (int'(bit_div) + 1));
          last_edge = cyc;
        end
      end else begin
        last_edge = -1;
      end
      prev_sclk = sclk_o;
    end
  end

  task automatic push_word(input logic [DATA_W-1:0] w);
    if (clk_en_exp())
      for (int i = 0; i < DATA_W; i++)
        exp_q.push_back({w[i], sync_mode ? rts_act : ~rts_act, sync_mode && (i == 0)});
  endtask

  task automatic check_idle(input string tag);
    chk(busy_o == 1'b0, {tag, " R10 busy low"}, int'(busy_o), 0);
    chk(sout_o == 1'b1, {tag, " R2 idle mark"}, int'(sout_o), 1);
    chk(sclk_o == standby_exp(), {tag, " R3 standby level"}, int'(sclk_o), int'(standby_exp()));
    chk(rts_o == ~rts_act, {tag, " R7 rts inactive"}, int'(rts_o), int'(~rts_act));
    chk(sds_o == 1'b0, {tag, " R8 sds low"}, int'(sds_o), 0);
    chk(exp_q.size() == 0, {tag, " R3 all bits clocked"}, exp_q.size(), 0);
  endtask

  task automatic run_frame(input logic [DATA_W-1:0] w, input bit poke);
    int n;
    int len;
    len = 16 * (int'(bit_div) + 1);
    push_word(w);
    @(negedge clk);
    data = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
    n = 0;
    while (busy_o && n < 100000) begin
      n++;
      if (n == 1) begin
        chk(rts_o == (sync_mode ? rts_act : ~rts_act), "R7 rts from first cell",
            int'(rts_o), int'(sync_mode ? rts_act : ~rts_act));
        chk(sds_o == sync_mode, "R8 sds on first cell", int'(sds_o), int'(sync_mode));
      end
      if (n == 2 * (int'(bit_div) + 1) + 1)
        chk(sds_o == 1'b0, "R8 sds low on second cell", int'(sds_o), 0);
      if (n == len)
        chk(rts_o == (sync_mode ? rts_act : ~rts_act), "R7 rts held through last cell",
            int'(rts_o), int'(sync_mode ? rts_act : ~rts_act));
      if (!clk_en_exp() && n == int'(bit_div) + 2)
        chk(sclk_o == standby_exp(), "R6/R9 clock held", int'(sclk_o), int'(standby_exp()));
      if (poke && n == 20) begin data = ~w; start = 1'b1; end
      if (poke && n == 21) start = 1'b0;
      @(negedge clk);
    end
    chk(n == len, "R10 frame length", n, len);
    check_idle("post-frame");
  endtask

  task automatic back_to_back(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    int gap;
    push_word(a);
    push_word(b);
    @(negedge clk);
    data = a; start = 1'b1;
    @(negedge clk);
    data = b;
    while (busy_o) @(negedge clk);
    gap = 0;
    while (!busy_o && gap < 10) begin gap++; @(negedge clk); end
    start = 1'b0;
    chk(gap == 1, "R10 one idle cycle between held starts", gap, 1);
    while (busy_o) @(negedge clk);
    check_idle("back-to-back");
  endtask

  task automatic main_seq();
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
    chk(sout_o == 1'b1, "R1 reset sout", int'(sout_o), 1);
    chk(sds_o == 1'b0, "R1 reset sds", int'(sds_o), 0);
    chk(rts_o == ~rts_act, "R1 reset rts", int'(rts_o), int'(~rts_act));
    rst_n = 1'b1;
    @(negedge clk);
    // R5: idle low, rising edge
    run_frame(8'hA5, 1'b0);
    // R5: idle high, falling edge, rts active low
    clk_idle = 1'b1; clk_rise = 1'b0; rts_act = 1'b0; bit_div = 8'd2;
    run_frame(8'h3C, 1'b0);
    // R5: standby equal to active level, fastest rate
    clk_idle = 1'b1; clk_rise = 1'b1; rts_act = 1'b1; bit_div = 8'd0;
    run_frame(8'h81, 1'b0);
    // R4: serial expansion
    sync_mode = 1'b0; clk_sel = 2'b11; bit_div = 8'd1;
    run_frame(8'h5A, 1'b0);
    // R9: not sync, other select
    clk_sel = 2'b01;
    run_frame(8'hC3, 1'b0);
    // R6: sync, clock off
    sync_mode = 1'b1; clk_sel = 2'b00; clk_idle = 1'b0;
    run_frame(8'h0F, 1'b0);
    // R10: start during frame ignored
    clk_sel = 2'b10; clk_rise = 1'b0; bit_div = 8'd3;
    run_frame(8'h96, 1'b1);
    // R10: start held across frame end
    bit_div = 8'd1;
    back_to_back(8'hE1, 8'h1E);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      main_seq();
      begin
        #(5.0 * 150000);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule